// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block lets synchronous logic read and write an external 32K x 8 asynchronous static RAM. A requester presents a single access (direction flag, address and, for writes, one data byte) on a valid/ready handshake. The controller drives the memory's address, active-low chip select, write enable and output enable, and it drives the data bus through separate output, input and output-enable signals, so the pad ring can build the tri-state buffer. Read data comes back on a response bus with a one-cycle valid strobe.

Every phase lasts a whole number of clock cycles. The counts come from parameters: the clock period and the memory's timing limits, each divided and rounded up. A read holds chip select and output enable low for the access time. A write lowers chip select and write enable together for the longest of the write-pulse, select-to-end, address-to-end, data-setup and write-cycle limits, and it keeps output enable high. After every read the controller waits out the memory's bus-release time before it can drive the bus again. When no access is in progress all three strobes sit high, which puts the memory in standby.

The sequencer has four states. In IDLE it waits for a request; a read request moves it to READ and a write request moves it to WRITE. READ goes to TURN when its wait expires, WRITE returns to IDLE when its wait expires, and TURN returns to IDLE when its wait expires.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, mem_cs_n, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0, req_ready is 1 and rsp_valid is 0.
- R2: Whenever req_ready is 1 (IDLE), mem_cs_n, mem_we_n and mem_oe_n are all 1 and mem_dq_oe is 0.
- R3: The controller accepts a read when req_valid and req_ready are both 1 and req_write is 0. It then holds mem_cs_n and mem_oe_n at 0 with mem_we_n at 1 for RD_CYC = ceil(max(T_AA, T_RC) / CLK) cycles. It captures mem_dq_i on the last edge of that window and presents the byte on rsp_rdata with rsp_valid at 1 for exactly one cycle.
- R4: The controller accepts a write when req_valid and req_ready are both 1 and req_write is 1. mem_cs_n and mem_we_n then fall on the same edge and stay at 0 for WR_CYC = ceil(max(T_WP, T_CW, T_AW, T_DW, T_WC) / CLK) cycles, then rise on the same edge. mem_dq_oe is 1 exactly while mem_we_n is 0, and mem_dq_o carries the request's byte.
- R5: mem_oe_n is 1 in every cycle where mem_we_n is 0.
- R6: After mem_oe_n rises at the end of a read, mem_dq_oe stays 0 for at least HZ_CYC = ceil(T_HZ / CLK) cycles.
- R7: After acceptance, req_ready stays 0 for WR_CYC cycles for a write and for RD_CYC + HZ_CYC cycles for a read. It then returns to 1.
- R8: mem_addr and mem_dq_o do not change while mem_cs_n stays 0, and mem_addr equals the accepted address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request (IDLE) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write byte |
| rsp_valid | output | 1 | One-cycle strobe: rsp_rdata holds read data |
| rsp_rdata | output | DATA_W | Read byte |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_o | output | DATA_W | Data toward the memory |
| mem_dq_i | input | DATA_W | Data from the memory |
| mem_dq_oe | output | 1 | Enable for the data-bus drivers |

## Verification
The bench uses a 64-byte configuration and a memory model. The model returns a poison byte until chip select and output enable have been low for the full access time, so an access wait that is too short returns wrong data rather than a lucky match.

The bench runs several sweeps over every address:
- A read of every address before any write, which tells preset contents apart from written ones.
- A write of a computed pattern, followed by a read back of every address.
- Interleaved write-then-read and read-then-write pairs. Only the read-then-write order exercises the bus turnaround, so a missing or short release wait shows up there.
- An overwrite with the complemented pattern, which separates a real store from stale data.

Busy lengths are compared for both directions. The model also counts write-pulse width, output enable during a write, early driving after a read and address movement.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_TURN
    } asram_state_e;

    // ceil(a / b)
    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_wait_cnt.sv
module asram_wait_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/asram_rd_capture.sv
module asram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_i,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture) begin
                rsp_rdata <= dq_i;
            end
        end
    end
endmodule

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4,
    parameter int RD_CYC = 7,
    parameter int WR_CYC = 7,
    parameter int HZ_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              cnt_done,
    output logic              cnt_load,
    output logic [CNT_W-1:0]  cnt_val,
    output logic              req_ready,
    output logic              capture,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe
);
    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_CYC - 1);
    localparam logic [CNT_W-1:0] HZ_LOAD = CNT_W'(HZ_CYC - 1);

    asram_state_e state_q, state_d;
    logic         accept;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign capture   = (state_q == ST_READ) && cnt_done;

    // Next state and wait-counter reload.
    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    cnt_load = 1'b1;
                    if (req_write) begin
                        state_d = ST_WRITE;
                        cnt_val = WR_LOAD;
                    end else begin
                        state_d = ST_READ;
                        cnt_val = RD_LOAD;
                    end
                end
            end
            ST_READ: begin
                if (cnt_done) begin
                    state_d  = ST_TURN;
                    cnt_load = 1'b1;
                    cnt_val  = HZ_LOAD;
                end
            end
            ST_WRITE: begin
                if (cnt_done) begin
                    state_d = ST_IDLE;
                end
            end
            ST_TURN: begin
                if (cnt_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered strobes, decoded from the next state so they switch glitch-free.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_cs_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
            mem_addr  <= '0;
            mem_dq_o  <= '0;
        end else begin
            mem_cs_n  <= !((state_d == ST_READ) || (state_d == ST_WRITE));
            mem_we_n  <= !(state_d == ST_WRITE);
            mem_oe_n  <= !(state_d == ST_READ);
            mem_dq_oe <= (state_d == ST_WRITE);
            if (accept) begin
                mem_addr <= req_addr;
                mem_dq_o <= req_wdata;
            end
        end
    end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W  = 15,
    parameter int DATA_W  = 8,
    parameter int CLK_NS  = 10,
    parameter int T_AA_NS = 70,
    parameter int T_RC_NS = 70,
    parameter int T_WP_NS = 50,
    parameter int T_CW_NS = 60,
    parameter int T_AW_NS = 60,
    parameter int T_DW_NS = 30,
    parameter int T_WC_NS = 70,
    parameter int T_HZ_NS = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_o,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic              mem_dq_oe
);
    localparam int RD_CYC = imax(1, cdiv(imax(T_AA_NS, T_RC_NS), CLK_NS));
    localparam int WR_NS  = imax(imax(imax(T_WP_NS, T_CW_NS), imax(T_AW_NS, T_DW_NS)), T_WC_NS);
    localparam int WR_CYC = imax(1, cdiv(WR_NS, CLK_NS));
    localparam int HZ_CYC = imax(1, cdiv(T_HZ_NS, CLK_NS));
    localparam int CNT_W  = $clog2(imax(imax(RD_CYC, WR_CYC), HZ_CYC) + 1);

    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_done;
    logic             capture;

    asram_wait_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .done     (cnt_done)
    );

    asram_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .RD_CYC (RD_CYC),
        .WR_CYC (WR_CYC),
        .HZ_CYC (HZ_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .cnt_done  (cnt_done),
        .cnt_load  (cnt_load),
        .cnt_val   (cnt_val),
        .req_ready (req_ready),
        .capture   (capture),
        .mem_addr  (mem_addr),
        .mem_cs_n  (mem_cs_n),
        .mem_we_n  (mem_we_n),
        .mem_oe_n  (mem_oe_n),
        .mem_dq_o  (mem_dq_o),
        .mem_dq_oe (mem_dq_oe)
    );

    asram_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .dq_i      (mem_dq_i),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8,
    parameter int HZ_CYC = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [DATA_W-1:0] mem_dq_o,
    input logic              mem_dq_oe
);
    localparam int HW = $clog2(HZ_CYC + 2) + 1;
    localparam logic [HW-1:0] SAT = HW'(HZ_CYC + 1);

    // Cycles elapsed with output enable high, saturating.
    logic [HW-1:0] oe_hi_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_hi_cnt <= SAT;
        end else if (!mem_oe_n) begin
            oe_hi_cnt <= '0;
        end else if (oe_hi_cnt != SAT) begin
            oe_hi_cnt <= oe_hi_cnt + 1'b1;
        end
    end

    p_standby_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe));

    p_rsp_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_write_strobes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs_n && mem_dq_oe));

    p_drive_only_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> !mem_we_n);

    p_oe_off_in_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    p_turnaround_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (oe_hi_cnt >= HW'(HZ_CYC)));

    p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_addr_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_dq_o)));
endmodule

bind asram_ctrl asram_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .HZ_CYC (HZ_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/tb_asram_ctrl.sv
`timescale 1ns/1ps
module tb_asram_ctrl;
    localparam int AW    = 6;
    localparam int DW    = 8;
    localparam int CLK   = 5;
    localparam int DEPTH = 1 << AW;
    localparam int N_RD  = (70 + CLK - 1) / CLK;
    localparam int N_WR  = (70 + CLK - 1) / CLK;
    localparam int N_HZ  = (25 + CLK - 1) / CLK;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid, req_ready, req_write;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_o, mem_dq_i;

    always #2.5 clk = ~clk;

    asram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLK)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o), .mem_dq_i(mem_dq_i),
        .mem_dq_oe(mem_dq_oe)
    );

    // ---------------- memory model ----------------
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] ref_mem [DEPTH];
    int acc_cnt, wr_len, oe_hi;
    int viol_r4, viol_r5, viol_r6, viol_r8;
    logic [AW-1:0] wr_addr_l;
    logic [DW-1:0] wr_data_l;
    logic          cs_prev;
    logic [AW-1:0] addr_prev;

    assign mem_dq_i = (!mem_cs_n && !mem_oe_n && mem_we_n && acc_cnt >= N_RD - 1)
                      ? mem[mem_addr] : 8'hEE;

    always @(posedge clk) begin
        if (!rst_n) begin
            acc_cnt <= 0; wr_len <= 0; oe_hi <= N_HZ + 1;
            cs_prev <= 1'b1; addr_prev <= '0;
        end else begin
            acc_cnt <= (!mem_cs_n && !mem_oe_n) ? acc_cnt + 1 : 0;
            oe_hi   <= !mem_oe_n ? 0 : oe_hi + 1;
            if (!mem_we_n && !mem_oe_n) viol_r5 <= viol_r5 + 1;
            if (mem_dq_oe && oe_hi < N_HZ) viol_r6 <= viol_r6 + 1;
            if (!mem_cs_n && !cs_prev && mem_addr != addr_prev) viol_r8 <= viol_r8 + 1;
            cs_prev   <= mem_cs_n;
            addr_prev <= mem_addr;
            if (!mem_cs_n && !mem_we_n) begin
                if (!mem_dq_oe) viol_r4 <= viol_r4 + 1;
                if (wr_len != 0 && mem_dq_o != wr_data_l) viol_r8 <= viol_r8 + 1;
                wr_len    <= wr_len + 1;
                wr_addr_l <= mem_addr;
                wr_data_l <= mem_dq_o;
            end else if (wr_len != 0) begin
                if (wr_len != N_WR || mem_cs_n != mem_we_n) viol_r4 <= viol_r4 + 1;
                else mem[wr_addr_l] <= wr_data_l;
                wr_len <= 0;
            end
        end
    end

    // ---------------- checking ----------------
    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic standby_chk(input string tag);
        check(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe, tag,
              {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
    endtask

    task automatic access(input bit wr, input int a, input logic [DW-1:0] d);
        int busy = 0, pulses = 0;
        logic [DW-1:0] got = '0;
        req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) begin
            if (rsp_valid) begin pulses++; got = rsp_rdata; end
            busy++;
            @(negedge clk);
        end
        standby_chk("R2 idle standby");
        if (wr) begin
            ref_mem[a] = d;
            check(busy == N_WR, "R7 write busy", busy, N_WR);
        end else begin
            check(busy == N_RD + N_HZ, "R7 read busy", busy, N_RD + N_HZ);
            check(pulses == 1, "R3 one rsp pulse", pulses, 1);
            check(got == ref_mem[a], "R3 read data", got, ref_mem[a]);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int a);
        return DW'(a * 37 + 11);
    endfunction

    initial begin
        viol_r4 = 0; viol_r5 = 0; viol_r6 = 0; viol_r8 = 0;
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = DW'(i ^ 8'hA5);
            ref_mem[i] = DW'(i ^ 8'hA5);
        end
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        standby_chk("R1 reset strobes");
        check(req_ready && !rsp_valid, "R1 reset handshake", {req_ready, rsp_valid}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);
        standby_chk("R1 after reset strobes");
        check(req_ready && !rsp_valid, "R1 after reset handshake", {req_ready, rsp_valid}, 2'b10);

        for (int a = 0; a < DEPTH; a++) access(1'b0, a, '0);          // preset contents
        for (int a = 0; a < DEPTH; a++) access(1'b1, a, pat(a));      // R4 write sweep
        for (int a = 0; a < DEPTH; a++) access(1'b0, a, '0);          // read back
        for (int a = 0; a < DEPTH; a += 3) begin                      // R6 read then write
            access(1'b0, a, '0);
            access(1'b1, (a + 5) % DEPTH, ~pat(a));
            access(1'b0, (a + 5) % DEPTH, '0);
        end
        for (int a = 0; a < DEPTH; a++) access(1'b1, a, ~pat(a));     // overwrite
        for (int a = DEPTH - 1; a >= 0; a--) access(1'b0, a, '0);

        check(viol_r4 == 0, "R4 write pulse shape", viol_r4, 0);
        check(viol_r5 == 0, "R5 oe high during write", viol_r5, 0);
        check(viol_r6 == 0, "R6 bus turnaround", viol_r6, 0);
        check(viol_r8 == 0, "R8 address/data stable", viol_r8, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule